// File: doc/BRIEF.md
# Wake-up Pattern Filter

This block watches the received byte stream while the receiver is in wake-up detection mode and looks for frames that carry a programmed pattern. Four independent filters each choose up to 31 byte positions inside a window. The window starts at a programmable offset from the first byte of the frame. Each filter runs a CRC-16 over only the bytes it selects. When the last selected byte arrives, the filter compares the running CRC with its programmed value. A match latches a wake cause and the number of the filter that matched. The cause stays latched until the host clears it.

The byte stream uses valid/ready. The block never applies back-pressure: `s_ready` is tied high and every byte offered with `s_valid` high is consumed in that cycle. Bytes are counted only while detection mode is on. Normal reception is held off while detection mode is on. The filters are programmed through one data word port with an internal sequential index, and the index can be rewound to the first word. Energy-based and magic-frame wake sources live outside this block. Their cause codes are reserved in the status field.

Top module: `wake_pattern_filter`

## Requirements
- R1: After reset, `wake_status` is 00 and `wake_filter` is 0. `rx_enable` is 1 while `wake_en` is low, `s_ready` is 1, every filter is disabled and the configuration index points at word 0.
- R2: `rx_enable` is the inverse of `wake_en`. Bytes offered while `wake_en` is low are ignored and raise no wake event. A frame that was in progress when `wake_en` dropped is abandoned.
- R3: Each `cfg_we` pulse writes `cfg_data` to the word at the current index and then advances the index by one. The index wraps from 7 back to 0. Words 0 to 3 hold the masks of filters 0 to 3. Word 4 bits 3:0 hold the per-filter enables. Word 5 holds the start offsets, with filter k in bits 8k+7:8k. Word 6 holds the expected CRCs of filter 0 (bits 15:0) and filter 1 (bits 31:16). Word 7 does the same for filters 2 and 3. `cfg_restart` sets the index to 0 and wins over a write in the same cycle.
- R4: The byte accepted with `s_sof` is position 0, and later bytes of the frame are numbered upward. Mask bit j selects the byte at position offset+j for j in 0..30. Mask bit 31 is ignored.
- R5: The CRC is CRC-16 with polynomial 0x8005, initial value 0xFFFF, and data fed least significant bit first (register shifted right, reflected polynomial 0xA001). There is no final inversion. It covers only the selected bytes, in stream order.
- R6: The comparison happens on the highest selected position. If the CRC including that byte equals the programmed value, `wake_status` becomes 10 (frame pattern) and `wake_filter` holds the filter index. Both are visible after the clock edge that accepted the byte. A differing CRC raises nothing.
- R7: A frame whose `s_eof` byte comes before the filter's highest selected position does not match that filter. The next `s_sof` restarts the position count and the CRC.
- R8: A disabled filter, or a filter whose mask bits 30:0 are all zero, never matches.
- R9: A nonzero `wake_status` and its `wake_filter` hold until `wake_clr`. Later matches do not overwrite the first cause. `wake_clr` returns the field to 00. A match while the field is 00 is recorded even if `wake_clr` is high in the same cycle.
- R10: When several filters match on the same byte, the lowest filter index is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_en | input | 1 | Wake-up pattern detection mode |
| rx_enable | output | 1 | Normal reception allowed (low in detection mode) |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready, always 1 |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| cfg_we | input | 1 | Write configuration word at current index |
| cfg_restart | input | 1 | Rewind configuration index to word 0 |
| cfg_data | input | 32 | Configuration word |
| wake_clr | input | 1 | Clear the latched wake cause |
| wake_status | output | 2 | Wake cause: 00 none, 01 energy (reserved), 10 frame pattern |
| wake_filter | output | 2 | Index of the filter that caused the wake |

## Verification
The assertions watch on every cycle that the latched cause and filter index stay stable until a clear, and that a clear empties the field. They also check that a hit when the field is empty always records, that filter 0 wins when it hits, and that nothing wakes while detection is off. They also track the configuration index through its advance, wrap and rewind. Only the bench's frames can show that the CRC over the selected bytes, the offset arithmetic, the ignored mask bit 31 and the early end of a frame give the right answers. The bench also shows that a misaligned configuration lands in the wrong fields. For each frame, the bench computes the expected winner with its own model of the filters.

// File: rtl/wpf_pkg.sv
package wpf_pkg;

  typedef enum logic [1:0] {
    WAKE_NONE    = 2'b00,
    WAKE_ENERGY  = 2'b01,
    WAKE_PATTERN = 2'b10
  } wake_cause_e;

  localparam int          CRC_W         = 16;
  localparam logic [15:0] CRC_SEED      = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

  // One byte through the reflected CRC-16 register, LSB of the byte first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/wpf_cfg_regs.sv
module wpf_cfg_regs #(
  parameter int NUM_FILT = 4,
  parameter int MASK_W   = 31,
  parameter int OFF_W    = 8,
  parameter int CFG_W    = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic                               cfg_restart,
  input  logic [CFG_W-1:0]                   cfg_data,
  output logic [NUM_FILT-1:0][MASK_W-1:0]    mask_o,
  output logic [NUM_FILT-1:0]                en_o,
  output logic [NUM_FILT-1:0][OFF_W-1:0]     off_o,
  output logic [NUM_FILT-1:0][15:0]          crc_o
);
  localparam int OFF_WORDS = (NUM_FILT * OFF_W + CFG_W - 1) / CFG_W;
  localparam int CRC_WORDS = (NUM_FILT * 16 + CFG_W - 1) / CFG_W;
  localparam int EN_IDX    = NUM_FILT;
  localparam int OFF_BASE  = NUM_FILT + 1;
  localparam int CRC_BASE  = OFF_BASE + OFF_WORDS;
  localparam int NUM_WORDS = CRC_BASE + CRC_WORDS;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int LAST_IDX  = NUM_WORDS - 1;

  logic [IDX_W-1:0]                 idx_q;
  logic [NUM_FILT-1:0][MASK_W-1:0]  mask_q;
  logic [NUM_FILT-1:0]              en_q;
  logic [OFF_WORDS*CFG_W-1:0]       off_store;
  logic [CRC_WORDS*CFG_W-1:0]       crc_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      mask_q    <= '0;
      en_q      <= '0;
      off_store <= '0;
      crc_store <= '0;
    end else if (cfg_restart) begin
      idx_q <= '0;
    end else if (cfg_we) begin
      idx_q <= (idx_q == IDX_W'(LAST_IDX)) ? '0 : idx_q + 1'b1;
      for (int k = 0; k < NUM_FILT; k++)
        if (idx_q == IDX_W'(k)) mask_q[k] <= cfg_data[MASK_W-1:0];
      if (idx_q == IDX_W'(EN_IDX)) en_q <= cfg_data[NUM_FILT-1:0];
      for (int k = 0; k < OFF_WORDS; k++)
        if (idx_q == IDX_W'(OFF_BASE + k)) off_store[k*CFG_W +: CFG_W] <= cfg_data;
      for (int k = 0; k < CRC_WORDS; k++)
        if (idx_q == IDX_W'(CRC_BASE + k)) crc_store[k*CFG_W +: CFG_W] <= cfg_data;
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;

  for (genvar g = 0; g < NUM_FILT; g++) begin : g_unpack
    assign off_o[g] = off_store[g*OFF_W +: OFF_W];
    assign crc_o[g] = crc_store[g*16 +: 16];
  end

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_restart && idx_q == IDX_W'(LAST_IDX)) |=> (idx_q == '0)); // R3
  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_restart |=> (idx_q == '0)); // R3
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !cfg_restart) |=> $stable(idx_q)); // R3

endmodule

// File: rtl/wpf_lane.sv
module wpf_lane
  import wpf_pkg::*;
#(
  parameter int MASK_W = 31,
  parameter int OFF_W  = 8,
  parameter int POS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sof,
  input  logic [7:0]        data,
  input  logic [POS_W-1:0]  pos,
  input  logic              en,
  input  logic [MASK_W-1:0] mask,
  input  logic [OFF_W-1:0]  off,
  input  logic [15:0]       expect_crc,
  output logic              hit
);
  localparam int MIDX_W = $clog2(MASK_W);

  function automatic logic [MIDX_W-1:0] top_set(input logic [MASK_W-1:0] m);
    logic [MIDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < MASK_W; i++)
      if (m[i]) r = MIDX_W'(i);
    return r;
  endfunction

  logic [15:0]       crc_q, crc_base, crc_nx;
  logic [POS_W-1:0]  rel;
  logic [MIDX_W-1:0] rel_idx, last_idx;
  logic              in_win, sel;

  always_comb begin
    rel      = pos - POS_W'(off);
    in_win   = (pos >= POS_W'(off)) && (rel < POS_W'(MASK_W));
    rel_idx  = rel[MIDX_W-1:0];
    sel      = take && en && in_win && mask[rel_idx];
    crc_base = sof ? CRC_SEED : crc_q;
    crc_nx   = sel ? crc16_step(crc_base, data) : crc_base;
    last_idx = top_set(mask);
  end

  assign hit = sel && (rel_idx == last_idx) && (crc_nx == expect_crc);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_nx;
  end

  AST_CRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take) |=> $stable(crc_q)); // R5

endmodule

// File: rtl/wpf_status.sv
module wpf_status
  import wpf_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int FID_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FILT-1:0] hit_vec,
  input  logic                clr,
  output wake_cause_e         status,
  output logic [FID_W-1:0]    src
);
  logic [FID_W-1:0] first;
  logic             found;

  always_comb begin
    first = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_FILT; i++) begin
      if (hit_vec[i] && !found) begin
        first = FID_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= WAKE_NONE;
      src    <= '0;
    end else if (status == WAKE_NONE && found) begin
      status <= WAKE_PATTERN;
      src    <= first;
    end else if (clr) begin
      status <= WAKE_NONE;
      src    <= '0;
    end
  end

  AST_STICKY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (status != WAKE_NONE && !clr) |=> ($stable(status) && $stable(src))); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (status != WAKE_NONE && clr) |=> (status == WAKE_NONE)); // R9
  AST_HIT_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == WAKE_NONE && hit_vec != '0) |=> (status == WAKE_PATTERN)); // R6
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (status == WAKE_NONE && hit_vec[0]) |=> (src == '0)); // R10

endmodule

// File: rtl/wake_pattern_filter.sv
module wake_pattern_filter
  import wpf_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int MASK_W   = 31,
  parameter int OFF_W    = 8,
  parameter int CFG_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake_en,
  output logic                 rx_enable,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [7:0]           s_data,
  input  logic                 s_sof,
  input  logic                 s_eof,
  input  logic                 cfg_we,
  input  logic                 cfg_restart,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 wake_clr,
  output logic [1:0]           wake_status,
  output logic [((NUM_FILT > 1) ? $clog2(NUM_FILT) : 1)-1:0] wake_filter
);
  localparam int FID_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1;
  localparam int POS_W   = $clog2((2 ** OFF_W) + MASK_W + 1);
  localparam int POS_MAX = (2 ** POS_W) - 1;

  logic [NUM_FILT-1:0][MASK_W-1:0] mask;
  logic [NUM_FILT-1:0]             en;
  logic [NUM_FILT-1:0][OFF_W-1:0]  off;
  logic [NUM_FILT-1:0][15:0]       exp_crc;
  logic [NUM_FILT-1:0]             hit_vec;

  logic             in_frame_q, acc, take;
  logic [POS_W-1:0] pos_q, pos_eff;
  wake_cause_e      status;

  assign s_ready   = 1'b1;
  assign rx_enable = !wake_en;
  assign acc       = s_valid && wake_en;
  assign take      = acc && (s_sof || in_frame_q);
  assign pos_eff   = s_sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else if (!wake_en) begin
      in_frame_q <= 1'b0;
    end else if (take) begin
      in_frame_q <= !s_eof;
      pos_q      <= (pos_eff == POS_W'(POS_MAX)) ? pos_eff : pos_eff + 1'b1;
    end
  end

  wpf_cfg_regs #(
    .NUM_FILT(NUM_FILT), .MASK_W(MASK_W), .OFF_W(OFF_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_restart(cfg_restart),
    .cfg_data(cfg_data), .mask_o(mask), .en_o(en), .off_o(off), .crc_o(exp_crc)
  );

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_lane
    wpf_lane #(.MASK_W(MASK_W), .OFF_W(OFF_W), .POS_W(POS_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .take(take), .sof(s_sof), .data(s_data),
      .pos(pos_eff), .en(en[f]), .mask(mask[f]), .off(off[f]),
      .expect_crc(exp_crc[f]), .hit(hit_vec[f])
    );
  end

  wpf_status #(.NUM_FILT(NUM_FILT), .FID_W(FID_W)) u_status (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .clr(wake_clr),
    .status(status), .src(wake_filter)
  );

  assign wake_status = status;

  AST_NO_WAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_en && wake_status == 2'b00) |=> (wake_status == 2'b00)); // R2
  AST_HIT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |-> (s_valid && wake_en)); // R2
  AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (take && s_sof && !s_eof) |=> (pos_q == POS_W'(1))); // R4

endmodule

// File: tb/test_wake_pattern_filter.sv
module test_wake_pattern_filter;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, wake_en, rx_enable, s_valid, s_ready, s_sof, s_eof;
  logic [7:0] s_data;
  logic cfg_we, cfg_restart, wake_clr;
  logic [31:0] cfg_data;
  logic [1:0] wake_status, wake_filter;

  always #(CLK_P/2) clk = ~clk;

  wake_pattern_filter i_wake_pattern_filter (
    .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .rx_enable(rx_enable),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof),
    .s_eof(s_eof), .cfg_we(cfg_we), .cfg_restart(cfg_restart),
    .cfg_data(cfg_data), .wake_clr(wake_clr), .wake_status(wake_status),
    .wake_filter(wake_filter)
  );

  int n_checks = 0;
  int n_err = 0;
  int exp_q[$];

  logic [7:0]  fr [0:127];
  int          fr_len;
  logic [31:0] b_mask [4];
  int          b_off  [4];
  logic [15:0] b_crc  [4];
  bit          b_en   [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // R5 reference: reflected 0x8005, seed 0xFFFF, LSB of each byte first
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] s;
    logic fb;
    s = c;
    for (int b = 0; b < 8; b++) begin
      fb = s[0] ^ d[b];
      s  = {1'b0, s[15:1]};
      if (fb) s = s ^ 16'hA001;
    end
    return s;
  endfunction

  function automatic logic [15:0] crc_for(input int f);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int j = 0; j < 31; j++)
      if (b_mask[f][j] && (b_off[f] + j) < 128) c = ref_crc(c, fr[b_off[f] + j]);
    return c;
  endfunction

  // Earliest-completing matching filter, lowest index on a tie; -1 if none
  function automatic int model_hit();
    int best, bestpos, top, lastp;
    logic [15:0] c;
    best = -1;
    bestpos = 1 << 20;
    for (int f = 0; f < 4; f++) begin
      top = -1;
      for (int j = 0; j < 31; j++) if (b_mask[f][j]) top = j;
      if (b_en[f] && top >= 0) begin
        lastp = b_off[f] + top;
        if (lastp < fr_len) begin
          c = crc_for(f);
          if (c == b_crc[f] && lastp < bestpos) begin
            best = f;
            bestpos = lastp;
          end
        end
      end
    end
    return best;
  endfunction

  task automatic fill(input int kind);
    for (int i = 0; i < 128; i++) begin
      case (kind)
        0: fr[i] = 8'(i * 7 + 3);
        1: fr[i] = 8'(i * 13 + 8'h55);
        2: fr[i] = 8'(i) ^ 8'hA5;
        default: fr[i] = ~8'(i);
      endcase
    end
  endtask

  task automatic cfg_write(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_data = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_cfg();
    for (int f = 0; f < 4; f++) cfg_write(b_mask[f]);
    cfg_write({28'd0, b_en[3], b_en[2], b_en[1], b_en[0]});
    cfg_write({8'(b_off[3]), 8'(b_off[2]), 8'(b_off[1]), 8'(b_off[0])});
    cfg_write({b_crc[1], b_crc[0]});
    cfg_write({b_crc[3], b_crc[2]});
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = fr[i];
      s_sof   = (i == 0);
      s_eof   = (i == len - 1);
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_sof   = 1'b0;
    s_eof   = 1'b0;
  endtask

  task automatic run_case(input int len, input string req);
    int e;
    fr_len = len;
    e = model_hit();
    if (e >= 0) exp_q.push_back(e);
    send_frame(len);
    @(negedge clk);
    if (e < 0) begin
      chk(wake_status == 2'b00, req, "no wake expected", wake_status, 0);
    end else begin
      chk(exp_q.size() == 0, req, "wake event seen", exp_q.size(), 0);
      chk(wake_status == 2'b10, req, "pattern cause", wake_status, 2);
    end
  endtask

  task automatic clear_wake();
    @(negedge clk);
    wake_clr = 1'b1;
    @(negedge clk);
    wake_clr = 1'b0;
    chk(wake_status == 2'b00, "R9", "cleared status", wake_status, 0);
  endtask

  // Monitor: pops the scoreboard on each new wake event
  logic [1:0] prev_st;
  always @(negedge clk) begin
    int e;
    if (!rst_n) begin
      prev_st = 2'b00;
    end else begin
      if (wake_status != 2'b00 && prev_st == 2'b00) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected wake", wake_filter, -1);
        end else begin
          e = exp_q.pop_front();
          chk(wake_filter == 2'(e), "R6/R10", "wake filter index", wake_filter, e);
        end
      end
      prev_st = wake_status;
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_err++;
    n_checks++;
    $display("FAIL watchdog R1: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wake_en = 1'b0; s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    s_data = '0; cfg_we = 1'b0; cfg_restart = 1'b0; cfg_data = '0; wake_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wake_status == 2'b00, "R1", "reset status", wake_status, 0);
    chk(wake_filter == 2'd0, "R1", "reset filter", wake_filter, 0);
    chk(rx_enable == 1'b1, "R1", "reset rx_enable", rx_enable, 1);
    chk(s_ready == 1'b1, "R1", "s_ready", s_ready, 1);

    // Configuration
    b_mask[0] = 32'h8000_000F; b_off[0] = 0;  b_en[0] = 1;   // R4: bit 31 set, ignored
    b_mask[1] = 32'h0000_0005; b_off[1] = 12; b_en[1] = 1;
    b_mask[2] = 32'h4000_0001; b_off[2] = 20; b_en[2] = 1;
    b_mask[3] = 32'h0000_0300; b_off[3] = 30; b_en[3] = 0;
    fill(0); b_crc[0] = crc_for(0);
    fill(1); b_crc[1] = crc_for(1);
    fill(2); b_crc[2] = crc_for(2);
    fill(3); b_crc[3] = crc_for(3);

    // R3: partial writes then rewind; misalignment would break every match below
    cfg_write(32'hDEAD_BEEF); cfg_write(32'h1234_5678); cfg_write(32'hFFFF_FFFF);
    @(negedge clk); cfg_restart = 1'b1;
    @(negedge clk); cfg_restart = 1'b0;
    push_cfg();

    wake_en = 1'b1;
    @(negedge clk);
    chk(rx_enable == 1'b0, "R2", "rx_enable in detection mode", rx_enable, 0);

    fill(0); run_case(40, "R4 R5 R6 frame A");
    clear_wake();
    fill(1); run_case(40, "R6 frame B");
    clear_wake();
    fill(1); run_case(14, "R7 frame B truncated");
    fill(2); run_case(60, "R4 R6 wide window");
    clear_wake();
    fill(2); run_case(50, "R7 ends before last byte");
    fill(3); run_case(50, "R8 disabled filter");
    b_en[3] = 1; push_cfg();
    fill(3); run_case(50, "R8 enabled filter");
    clear_wake();

    b_crc[2] = b_crc[2] ^ 16'h0001; push_cfg();
    fill(2); run_case(60, "R6 crc mismatch");
    b_crc[2] = b_crc[2] ^ 16'h0001; push_cfg();

    // R9: sticky first cause
    fill(0); run_case(40, "R9 first cause");
    fill(1); fr_len = 40; send_frame(40);
    @(negedge clk);
    chk(wake_status == 2'b10, "R9", "sticky status", wake_status, 2);
    chk(wake_filter == 2'd0, "R9", "sticky filter", wake_filter, 0);
    clear_wake();

    // R2: detection off ignores bytes
    wake_en = 1'b0;
    fill(0); send_frame(40);
    @(negedge clk);
    chk(wake_status == 2'b00, "R2", "no wake when disabled", wake_status, 0);
    chk(rx_enable == 1'b1, "R2", "rx_enable restored", rx_enable, 1);
    wake_en = 1'b1;

    // R10: tie on the same byte
    b_mask[1] = 32'h0000_000F; b_off[1] = 0;
    fill(0); b_crc[1] = crc_for(1); push_cfg();
    fill(0); run_case(40, "R10 tie lowest index");
    clear_wake();
    b_en[0] = 0; push_cfg();
    fill(0); run_case(40, "R10 filter 1 alone");
    clear_wake();

    // R3 wrap: ninth write lands on word 0 (filter 0 mask)
    b_en[0] = 1; push_cfg();
    cfg_write(32'h0000_0000); b_mask[0] = 32'h0;
    fill(0); run_case(40, "R3 R8 wrapped write empties mask");
    clear_wake();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule